// File: doc/BRIEF.md
# Single-Pin Dual Dead-Time Calibrator

This block runs once after power-up. It measures how long one external RC network takes to charge and to discharge between fixed comparator thresholds, and from those times it derives two gate dead times. The longer-ratio value goes to the synchronous rectifier gates. The shorter-ratio value goes to the primary half-bridge gates. Only the digital part is in this block. The comparators deliver one flag per threshold (above 1.0 V, above 1.4 V, above 3.0 V), and the block returns an enable for the switched current sink on the pin.

The sequence has four steps. The block waits for the bias supply. It then waits for the pin to pass 1.4 V and pulls the pin down to 1.0 V. It releases the pin and counts clock ticks until the pin climbs to 3.0 V. Finally it pulls the pin down again and counts ticks until the pin reaches 1.0 V. After that the sink stays off for good. Each count is shifted right (truncating), clamped to the allowed dead-time range, and held for the gate-timing logic as a count of 25 ns ticks. The gate-timing logic runs at 40 MHz. While the converter is in light-load PWM operation, both outputs read twice their stored values.

Top module: `dead_time_cal`

## Requirements
- R1: From reset until calibration completes, `cal_done` is 0, `sink_en` is 0 outside the two discharge phases, and both `dt_sr` and `dt_pri` read DT_MAX (15), whatever the value of `pwm_mode`.
- R2: While `bias_ok` is 1, the sink stays off until `th_mid` is sampled high. `sink_en` then goes high on the next clock.
- R3: In the first discharge, `sink_en` stays high until `th_lo` is sampled low. It goes low on that clock edge, and rise counting starts from zero.
- R4: The rise interval is the number of clocks sampled with `th_hi` low after the first discharge ends. The clock that samples `th_hi` high captures this count and turns `sink_en` on again.
- R5: The fall interval is the number of clocks sampled with `th_lo` high in the second discharge. The clock that samples `th_lo` low captures this count, sets `cal_done`, and turns the sink off. After that, comparator inputs have no effect on `sink_en` or on either output until reset.
- R6: `dt_sr` equals the rise interval shifted right by 6 (truncated), clamped to the range 3..15.
- R7: `dt_pri` equals the fall interval shifted right by 5 (truncated), clamped to the range 3..15.
- R8: After completion, `pwm_mode` = 1 makes both outputs twice their calibrated value in the same cycle. `pwm_mode` = 0 restores the calibrated value.
- R9: Each interval counter saturates at 2^CNT_W-1 (4095 by default) and does not wrap. A very long interval therefore yields 15.
- R10: While `bias_ok` is 0 the block stays idle. Threshold flags are ignored and `sink_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_ok | input | 1 | Bias supply ready |
| th_lo | input | 1 | Pin above 1.0 V |
| th_mid | input | 1 | Pin above 1.4 V |
| th_hi | input | 1 | Pin above 3.0 V |
| pwm_mode | input | 1 | Light-load PWM operation active |
| sink_en | output | 1 | Enable for the switched discharge current |
| dt_sr | output | 5 | Rectifier dead time in ticks |
| dt_pri | output | 5 | Primary dead time in ticks |
| cal_done | output | 1 | Calibration complete |

## Verification
The bench uses the default parameters: a 12-bit counter, shifts of 6 and 5, and limits of 3 and 15. With these values every clamp boundary is reached with intervals of a few hundred ticks. Counter saturation at 4095 is also within reach in a run of about 4200 cycles, and it is distinguishable from wrap-around: a wrapped count would give the minimum value instead of the maximum. Directed intervals land exactly on shift boundaries, just below them, and below the minimum, to expose truncation and clamping errors in each channel separately.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int DEF_CNT_W     = 12;
    localparam int DEF_SR_SHIFT  = 6;
    localparam int DEF_PRI_SHIFT = 5;
    localparam int DEF_DT_MIN    = 3;
    localparam int DEF_DT_MAX    = 15;

    localparam int NUM_CH = 2;
    localparam int CH_SR  = 0;
    localparam int CH_PRI = 1;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_MID = 3'd1,
        ST_DISCH1   = 3'd2,
        ST_RISE     = 3'd3,
        ST_DISCH2   = 3'd4,
        ST_DONE     = 3'd5
    } cal_state_e;

    typedef struct packed {
        logic sink;
        logic cnt_clr;
        logic cnt_inc;
        logic cap_rise;
        logic cap_fall;
        logic done;
    } seq_ctl_t;

endpackage

// File: rtl/dtc_sequencer.sv
module dtc_sequencer
    import dtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bias_ok,
    input  logic     th_lo,
    input  logic     th_mid,
    input  logic     th_hi,
    output seq_ctl_t ctl
);

    cal_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        ctl          = '0;
        ctl.sink     = (state_q == ST_DISCH1) || (state_q == ST_DISCH2);
        ctl.done     = (state_q == ST_DONE);
        case (state_q)
            ST_IDLE: begin
                ctl.cnt_clr = 1'b1;
                if (bias_ok) state_d = ST_WAIT_MID;
            end
            ST_WAIT_MID: begin
                ctl.cnt_clr = 1'b1;
                if (th_mid) state_d = ST_DISCH1;
            end
            ST_DISCH1: begin
                ctl.cnt_clr = 1'b1;
                if (!th_lo) state_d = ST_RISE;
            end
            ST_RISE: begin
                if (th_hi) begin
                    ctl.cap_rise = 1'b1;
                    ctl.cnt_clr  = 1'b1;
                    state_d      = ST_DISCH2;
                end else begin
                    ctl.cnt_inc = 1'b1;
                end
            end
            ST_DISCH2: begin
                if (!th_lo) begin
                    ctl.cap_fall = 1'b1;
                    state_d      = ST_DONE;
                end else begin
                    ctl.cnt_inc = 1'b1;
                end
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dtc_sat_counter.sv
module dtc_sat_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != CNT_TOP))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dtc_scale_hold.sv
module dtc_scale_hold #(
    parameter int CNT_W  = 12,
    parameter int SHIFT  = 6,
    parameter int DT_MIN = 3,
    parameter int DT_MAX = 15,
    localparam int DT_BW = $clog2(DT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [CNT_W-1:0] cnt,
    output logic [DT_BW-1:0] base
);

    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(DT_MIN);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(DT_MAX);

    logic [CNT_W-1:0] quot;
    logic [DT_BW-1:0] clamped;

    always_comb begin
        quot = cnt >> SHIFT;
        if (quot < LIM_LO)      clamped = DT_BW'(DT_MIN);
        else if (quot > LIM_HI) clamped = DT_BW'(DT_MAX);
        else                    clamped = quot[DT_BW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      base <= DT_BW'(DT_MAX);
        else if (cap) base <= clamped;
    end

endmodule

// File: rtl/dead_time_cal.sv
module dead_time_cal
    import dtc_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int SR_SHIFT  = DEF_SR_SHIFT,
    parameter int PRI_SHIFT = DEF_PRI_SHIFT,
    parameter int DT_MIN    = DEF_DT_MIN,
    parameter int DT_MAX    = DEF_DT_MAX,
    localparam int DT_BW    = $clog2(DT_MAX + 1),
    localparam int DT_W     = DT_BW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bias_ok,
    input  logic            th_lo,
    input  logic            th_mid,
    input  logic            th_hi,
    input  logic            pwm_mode,
    output logic            sink_en,
    output logic [DT_W-1:0] dt_sr,
    output logic [DT_W-1:0] dt_pri,
    output logic            cal_done
);

    seq_ctl_t         ctl;
    logic [CNT_W-1:0] cnt;
    logic [NUM_CH-1:0] cap_vec;
    logic [DT_BW-1:0] base [NUM_CH];
    logic [DT_W-1:0]  dt_out [NUM_CH];

    dtc_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .bias_ok (bias_ok),
        .th_lo   (th_lo),
        .th_mid  (th_mid),
        .th_hi   (th_hi),
        .ctl     (ctl)
    );

    dtc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl.cnt_clr),
        .inc (ctl.cnt_inc),
        .cnt (cnt)
    );

    assign cap_vec[CH_SR]  = ctl.cap_rise;
    assign cap_vec[CH_PRI] = ctl.cap_fall;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int CH_SHIFT = (ch == CH_SR) ? SR_SHIFT : PRI_SHIFT;

        dtc_scale_hold #(
            .CNT_W  (CNT_W),
            .SHIFT  (CH_SHIFT),
            .DT_MIN (DT_MIN),
            .DT_MAX (DT_MAX)
        ) u_hold (
            .clk  (clk),
            .rst  (rst),
            .cap  (cap_vec[ch]),
            .cnt  (cnt),
            .base (base[ch])
        );

        always_comb begin
            if (!ctl.done)    dt_out[ch] = DT_W'(DT_MAX);
            else if (pwm_mode) dt_out[ch] = {base[ch], 1'b0};
            else              dt_out[ch] = {1'b0, base[ch]};
        end
    end

    assign sink_en  = ctl.sink;
    assign cal_done = ctl.done;
    assign dt_sr    = dt_out[CH_SR];
    assign dt_pri   = dt_out[CH_PRI];

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
    parameter int DT_MIN = 3,
    parameter int DT_MAX = 15,
    parameter int DT_W   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            sink_en,
    input logic            cal_done,
    input logic            pwm_mode,
    input logic [DT_W-1:0] dt_sr,
    input logic [DT_W-1:0] dt_pri
);

    AST_PRE_DONE_MAX: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> (dt_sr == DT_W'(DT_MAX)) && (dt_pri == DT_W'(DT_MAX))); // R1

    AST_NO_SINK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> !sink_en); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cal_done && $past(cal_done) && (pwm_mode == $past(pwm_mode)))
        |-> ($stable(dt_sr) && $stable(dt_pri))); // R5

    AST_SR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !pwm_mode) |-> (dt_sr >= DT_W'(DT_MIN)) && (dt_sr <= DT_W'(DT_MAX))); // R6

    AST_PRI_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !pwm_mode) |-> (dt_pri >= DT_W'(DT_MIN)) && (dt_pri <= DT_W'(DT_MAX))); // R7

    AST_PWM_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (cal_done && pwm_mode) |-> (!dt_sr[0] && !dt_pri[0]
            && (dt_sr >= DT_W'(2 * DT_MIN)) && (dt_pri >= DT_W'(2 * DT_MIN)))); // R8

endmodule

bind dead_time_cal dtc_checker #(
    .DT_MIN (DT_MIN),
    .DT_MAX (DT_MAX),
    .DT_W   (DT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sink_en  (sink_en),
    .cal_done (cal_done),
    .pwm_mode (pwm_mode),
    .dt_sr    (dt_sr),
    .dt_pri   (dt_pri)
);

// File: tb/dead_time_cal_tb.sv
`timescale 1ns/1ps
module dead_time_cal_tb;

    localparam int CLK_PERIOD = 25;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bias_ok = 1'b0;
    logic       th_lo = 1'b0;
    logic       th_mid = 1'b0;
    logic       th_hi = 1'b0;
    logic       pwm_mode = 1'b0;
    logic       sink_en;
    logic [4:0] dt_sr;
    logic [4:0] dt_pri;
    logic       cal_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    dead_time_cal u_dut (
        .clk      (clk),
        .rst      (rst),
        .bias_ok  (bias_ok),
        .th_lo    (th_lo),
        .th_mid   (th_mid),
        .th_hi    (th_hi),
        .pwm_mode (pwm_mode),
        .sink_en  (sink_en),
        .dt_sr    (dt_sr),
        .dt_pri   (dt_pri),
        .cal_done (cal_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_dt(input int ticks, input int shift);
        int sat;
        int q;
        sat = (ticks > 4095) ? 4095 : ticks;
        q = sat >> shift;
        if (q < 3)  q = 3;
        if (q > 15) q = 15;
        return q;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bias_ok = 1'b0; th_lo = 1'b0; th_mid = 1'b0; th_hi = 1'b0; pwm_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R1 cal_done", cal_done, 0);
        check("R1 sink_en", sink_en, 0);
        pwm_mode = 1'b1;
        #1;
        check("R1 dt_sr", dt_sr, 15);
        check("R1 dt_pri", dt_pri, 15);
        pwm_mode = 1'b0;
    endtask

    task automatic t_idle_ignore();
        do_reset();
        th_mid = 1'b1; th_lo = 1'b1; th_hi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R10 sink_en idle", sink_en, 0);
        end
        check("R10 cal_done idle", cal_done, 0);
    endtask

    task automatic run_cal(input int n_rise, input int n_fall);
        do_reset();
        bias_ok = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 sink off before mid", sink_en, 0);
        th_mid = 1'b1; th_lo = 1'b1;
        @(negedge clk);
        check("R2 sink on after mid", sink_en, 1);
        repeat (5) @(negedge clk);
        check("R3 sink held", sink_en, 1);
        th_lo = 1'b0; th_mid = 1'b0;
        @(negedge clk);
        check("R3 sink off at 1V", sink_en, 0);
        th_lo = 1'b1;
        repeat (n_rise) @(negedge clk);
        check("R4 sink off during rise", sink_en, 0);
        th_hi = 1'b1; th_mid = 1'b1;
        @(negedge clk);
        check("R4 sink on after 3V", sink_en, 1);
        th_hi = 1'b0;
        repeat (n_fall) @(negedge clk);
        check("R5 not done during fall", cal_done, 0);
        th_lo = 1'b0; th_mid = 1'b0;
        @(negedge clk);
        check("R5 cal_done", cal_done, 1);
        check("R5 sink released", sink_en, 0);
    endtask

    task automatic t_cal(input int n_rise, input int n_fall);
        int e_sr;
        int e_pri;
        e_sr  = ref_dt(n_rise, 6);
        e_pri = ref_dt(n_fall, 5);
        run_cal(n_rise, n_fall);
        check("R6 dt_sr", dt_sr, e_sr);
        check("R7 dt_pri", dt_pri, e_pri);
        pwm_mode = 1'b1;
        #1;
        check("R8 dt_sr doubled", dt_sr, 2 * e_sr);
        check("R8 dt_pri doubled", dt_pri, 2 * e_pri);
        @(negedge clk);
        pwm_mode = 1'b0;
        #1;
        check("R8 dt_sr restored", dt_sr, e_sr);
    endtask

    task automatic t_post_done_ignore();
        run_cal(640, 224);
        for (int i = 0; i < 8; i++) begin
            th_lo = i[0]; th_mid = i[1]; th_hi = i[2];
            @(negedge clk);
            check("R5 sink stays off", sink_en, 0);
        end
        check("R5 dt_sr held", dt_sr, 10);
        check("R5 dt_pri held", dt_pri, 7);
    endtask

    task automatic t_saturate();
        run_cal(4200, 4200);
        check("R9 dt_sr saturated", dt_sr, 15);
        check("R9 dt_pri saturated", dt_pri, 15);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_idle_ignore();
        t_cal(640, 224);
        t_cal(100, 31);
        t_cal(703, 1000);
        t_cal(1023, 479);
        t_cal(191, 96);
        t_post_done_ignore();
        t_saturate();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule